// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the instruction decoder of a RISC-V core that implements the hypervisor extension. From the current privilege state and a handful of trap-control and environment-configuration fields, it decides which instruction classes must trap. For every class it gives an illegal-instruction flag, and for the classes that can trap to a hypervisor it also gives a virtual-instruction flag. The decoder matches each flag against the class of the instruction it is decoding.

The covered classes are the address-translation fences, the hypervisor load/store group, WFI, the three cache-block management operations, and the floating-point, vector and dynamic-rounding gates. The block also tells the memory side when a cache-block invalidate must be carried out as a flush. The block is purely combinational and holds no state.

Top module: `priv_legal_check`

## Requirements
- R1: The privilege state is a 2-bit level `priv_lvl_i` plus the bit `priv_virt_i`. Level 1 with virt 0 is HS, level 0 with virt 0 is HU, level 1 with virt 1 is VS, and level 0 with virt 1 is VU. Any level with bit 1 set is M. In M, `ill_o[8:0]`, `vi_o` and `inval_flush_o` are all 0.
- R2: Several `ill_o` bits cover the fences. Bit 0 (sfence.vma/sinval.vma) and bit 2 (hfence.gvma/hinval.gvma) are set in HU, or in HS when `ms_tvm_i`=1. Bit 1 (sfence.w.inval/sfence.inval.ir) and bit 3 (hfence.vvma/hinval.vvma) are set only in HU.
- R3: Several `vi_o` bits cover the fences. Bit 0 (sfence.vma/sinval.vma) is set in VU, or in VS when `hs_vtvm_i`=1. Bit 1 (sfence.w.inval/sfence.inval.ir) is set only in VU. Bit 2 (every hfence/hinval form) is set in VS and in VU.
- R4: `ill_o[4]` (hypervisor load/store) is set in HU when `hs_hu_i`=0. `vi_o[3]` is set in VS and in VU.
- R5: `ill_o[5]` (WFI) is set in HU, and in any mode other than M when `ms_tw_i`=1. `vi_o[4]` is set in VU when `ms_tw_i`=0, and in VS when `ms_tw_i`=0 and `hs_vtw_i`=1.
- R6: These gates apply in every mode, M included. `ill_o[9]` (FP/vector-FP) is set when `ms_fs_i`=2'b00. `ill_o[10]` (vector) is set when `ms_vs_i`=2'b00. `ill_o[11]` (dynamic rounding) is set when `frm_i` > 4.
- R7: For cache-block zero (`ill_o[6]`, `vi_o[5]`, enables `*_cbze_i`) and for clean/flush (`ill_o[7]`, `vi_o[6]`, enables `*_cbcfe_i`), the illegal bit is set in two cases: any mode other than M with the machine enable clear, or HU with the supervisor enable clear. The virtual bit is set when the machine enable is set and either the mode is VS with the hypervisor enable clear, or the mode is VU with the hypervisor or supervisor enable clear.
- R8: The invalidate control `*_cbie_i` encodes 2'b00 as Off, 2'b01 as Flush and 2'b11 as Invalidate; 2'b10 counts as Off. `ill_o[8]` is set in two cases: any mode other than M with the machine control Off, or HU with the supervisor control Off. `vi_o[7]` is set when the machine control is not Off and either the mode is VS with the hypervisor control Off, or the mode is VU with the hypervisor or supervisor control Off.
- R9: `inval_flush_o` is set when any control level that applies to the mode holds 2'b01. In HS that is machine only. In HU it is machine or supervisor. In VS it is machine or hypervisor. In VU it is machine, hypervisor or supervisor.
- R10: A virtual flag is never raised together with the illegal flag of the same class, and the illegal flag wins. `vi_o` is all zero whenever `priv_virt_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl_i | input | 2 | Privilege level (3/2 = M, 1 = supervisor, 0 = user) |
| priv_virt_i | input | 1 | Virtualization mode |
| ms_tvm_i | input | 1 | Trap virtual-memory management in HS |
| ms_tw_i | input | 1 | Timeout wait: trap WFI below M |
| ms_fs_i | input | 2 | Floating-point state, 2'b00 = Off |
| ms_vs_i | input | 2 | Vector state, 2'b00 = Off |
| hs_vtvm_i | input | 1 | Trap translation fences in VS |
| hs_vtw_i | input | 1 | Trap WFI in VS |
| hs_hu_i | input | 1 | Allow hypervisor load/store in HU |
| frm_i | input | 3 | Dynamic rounding mode |
| menv_cbze_i | input | 1 | Machine cache-block zero enable |
| menv_cbcfe_i | input | 1 | Machine cache-block clean/flush enable |
| menv_cbie_i | input | 2 | Machine cache-block invalidate control |
| henv_cbze_i | input | 1 | Hypervisor cache-block zero enable |
| henv_cbcfe_i | input | 1 | Hypervisor clean/flush enable |
| henv_cbie_i | input | 2 | Hypervisor invalidate control |
| senv_cbze_i | input | 1 | Supervisor cache-block zero enable |
| senv_cbcfe_i | input | 1 | Supervisor clean/flush enable |
| senv_cbie_i | input | 2 | Supervisor invalidate control |
| ill_o | output | 12 | Illegal-instruction flag per class |
| vi_o | output | 8 | Virtual-instruction flag per class |
| inval_flush_o | output | 1 | Perform cache-block invalidate as flush |

## Verification
The assertions assume the inputs are stable, known values whenever they are evaluated. Both reserved encodings may appear: level 2 and control value 2'b10. The assertions must hold for those too and do not exclude them. The stimulus drives each vector at a falling clock edge and holds it for a full cycle, so every assertion sees a settled input set. Two exhaustive sweeps cover all four level codes with both virt values: one over every trap bit, FS/VS state and rounding mode, the other over every enable and control combination of the three configuration levels.

// File: rtl/priv_legal_pkg.sv
package priv_legal_pkg;

    localparam int LVL_W   = 2;
    localparam int XS_W    = 2;
    localparam int CBIE_W  = 2;
    localparam int FRM_W   = 3;
    localparam int N_ILL   = 12;
    localparam int N_VIRT  = 8;
    localparam int N_CBEN  = 2;   // enable-bit cache-block classes: zero, clean/flush

    // illegal flag positions
    localparam int IL_SFVMA  = 0;
    localparam int IL_SFPART = 1;
    localparam int IL_HFG    = 2;
    localparam int IL_HFV    = 3;
    localparam int IL_HLSV   = 4;
    localparam int IL_WFI    = 5;
    localparam int IL_CBZ    = 6;
    localparam int IL_CBCF   = 7;
    localparam int IL_CBI    = 8;
    localparam int IL_FP     = 9;
    localparam int IL_VEC    = 10;
    localparam int IL_FRM    = 11;

    // virtual flag positions
    localparam int VI_SFVMA  = 0;
    localparam int VI_SFPART = 1;
    localparam int VI_HF     = 2;
    localparam int VI_HLSV   = 3;
    localparam int VI_WFI    = 4;
    localparam int VI_CBZ    = 5;
    localparam int VI_CBCF   = 6;
    localparam int VI_CBI    = 7;

    localparam logic [XS_W-1:0]   XS_OFF     = 2'b00;
    localparam logic [CBIE_W-1:0] CBIE_OFF   = 2'b00;
    localparam logic [CBIE_W-1:0] CBIE_FLUSH = 2'b01;
    localparam logic [CBIE_W-1:0] CBIE_RSVD  = 2'b10;
    localparam logic [CBIE_W-1:0] CBIE_INV   = 2'b11;

    typedef struct packed {
        logic m;
        logic hs;
        logic hu;
        logic vs;
        logic vu;
    } mode_t;

endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
    import priv_legal_pkg::*;
(
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             virt_i,
    output mode_t            mode_o
);

    always_comb begin
        mode_o = '0;
        if (lvl_i[1]) begin
            mode_o.m = 1'b1;
        end else begin
            unique case ({lvl_i[0], virt_i})
                2'b10:   mode_o.hs = 1'b1;
                2'b00:   mode_o.hu = 1'b1;
                2'b11:   mode_o.vs = 1'b1;
                default: mode_o.vu = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/priv_sys_rules.sv
module priv_sys_rules
    import priv_legal_pkg::*;
(
    input  mode_t mode_i,
    input  logic  tvm_i,
    input  logic  tw_i,
    input  logic  vtvm_i,
    input  logic  vtw_i,
    input  logic  hu_i,
    output logic  ill_sfvma_o,
    output logic  ill_sfpart_o,
    output logic  ill_hfg_o,
    output logic  ill_hfv_o,
    output logic  ill_hlsv_o,
    output logic  ill_wfi_o,
    output logic  vi_sfvma_o,
    output logic  vi_sfpart_o,
    output logic  vi_hf_o,
    output logic  vi_hlsv_o,
    output logic  vi_wfi_o
);

    logic guest;

    always_comb begin
        guest        = mode_i.vs | mode_i.vu;
        // native side
        ill_sfvma_o  = mode_i.hu | (mode_i.hs & tvm_i);
        ill_hfg_o    = mode_i.hu | (mode_i.hs & tvm_i);
        ill_sfpart_o = mode_i.hu;
        ill_hfv_o    = mode_i.hu;
        ill_hlsv_o   = mode_i.hu & ~hu_i;
        ill_wfi_o    = mode_i.hu | (~mode_i.m & tw_i);
        // guest side
        vi_sfvma_o   = mode_i.vu | (mode_i.vs & vtvm_i);
        vi_sfpart_o  = mode_i.vu;
        vi_hf_o      = guest;
        vi_hlsv_o    = guest;
        vi_wfi_o     = ~tw_i & (mode_i.vu | (mode_i.vs & vtw_i));
    end

endmodule

// File: rtl/cbo_enable_rule.sv
module cbo_enable_rule
    import priv_legal_pkg::*;
(
    input  mode_t mode_i,
    input  logic  m_en_i,
    input  logic  h_en_i,
    input  logic  s_en_i,
    output logic  ill_o,
    output logic  vi_o
);

    logic below_m;

    always_comb begin
        below_m = mode_i.hs | mode_i.hu | mode_i.vs | mode_i.vu;
        ill_o   = (below_m & ~m_en_i) | (mode_i.hu & ~s_en_i);
        vi_o    = m_en_i & ((mode_i.vs & ~h_en_i) |
                            (mode_i.vu & (~h_en_i | ~s_en_i)));
    end

endmodule

// File: rtl/cbo_inval_rule.sv
module cbo_inval_rule
    import priv_legal_pkg::*;
(
    input  mode_t             mode_i,
    input  logic [CBIE_W-1:0] m_ctl_i,
    input  logic [CBIE_W-1:0] h_ctl_i,
    input  logic [CBIE_W-1:0] s_ctl_i,
    output logic              ill_o,
    output logic              vi_o,
    output logic              flush_o
);

    function automatic logic is_off(input logic [CBIE_W-1:0] c);
        return (c == CBIE_OFF) || (c == CBIE_RSVD);
    endfunction

    logic m_off, h_off, s_off;
    logic m_fl, h_fl, s_fl;
    logic below_m;

    always_comb begin
        m_off   = is_off(m_ctl_i);
        h_off   = is_off(h_ctl_i);
        s_off   = is_off(s_ctl_i);
        m_fl    = (m_ctl_i == CBIE_FLUSH);
        h_fl    = (h_ctl_i == CBIE_FLUSH);
        s_fl    = (s_ctl_i == CBIE_FLUSH);
        below_m = mode_i.hs | mode_i.hu | mode_i.vs | mode_i.vu;

        ill_o   = (below_m & m_off) | (mode_i.hu & s_off);
        vi_o    = ~m_off & ((mode_i.vs & h_off) |
                            (mode_i.vu & (h_off | s_off)));
        flush_o = (mode_i.hs & m_fl) |
                  (mode_i.hu & (m_fl | s_fl)) |
                  (mode_i.vs & (m_fl | h_fl)) |
                  (mode_i.vu & (m_fl | h_fl | s_fl));
    end

endmodule

// File: rtl/priv_legal_check.sv
module priv_legal_check
    import priv_legal_pkg::*;
#(
    parameter int FRM_MAX = 4
) (
    input  logic [LVL_W-1:0]  priv_lvl_i,
    input  logic              priv_virt_i,
    input  logic              ms_tvm_i,
    input  logic              ms_tw_i,
    input  logic [XS_W-1:0]   ms_fs_i,
    input  logic [XS_W-1:0]   ms_vs_i,
    input  logic              hs_vtvm_i,
    input  logic              hs_vtw_i,
    input  logic              hs_hu_i,
    input  logic [FRM_W-1:0]  frm_i,
    input  logic              menv_cbze_i,
    input  logic              menv_cbcfe_i,
    input  logic [CBIE_W-1:0] menv_cbie_i,
    input  logic              henv_cbze_i,
    input  logic              henv_cbcfe_i,
    input  logic [CBIE_W-1:0] henv_cbie_i,
    input  logic              senv_cbze_i,
    input  logic              senv_cbcfe_i,
    input  logic [CBIE_W-1:0] senv_cbie_i,
    output logic [N_ILL-1:0]  ill_o,
    output logic [N_VIRT-1:0] vi_o,
    output logic              inval_flush_o
);

    localparam logic [FRM_W-1:0] FRM_LIM = FRM_W'(FRM_MAX);

    mode_t mode;

    logic ill_sfvma, ill_sfpart, ill_hfg, ill_hfv, ill_hlsv, ill_wfi;
    logic vi_sfvma, vi_sfpart, vi_hf, vi_hlsv, vi_wfi;
    logic ill_cbi, vi_cbi;

    logic [N_CBEN-1:0] cb_m_en, cb_h_en, cb_s_en;
    logic [N_CBEN-1:0] cb_ill, cb_vi;

    logic [N_ILL-1:0]  ill_d;
    logic [N_VIRT-1:0] vi_raw_d;
    logic [N_VIRT-1:0] vi_d;

    priv_mode_decode u_mode (
        .lvl_i  (priv_lvl_i),
        .virt_i (priv_virt_i),
        .mode_o (mode)
    );

    priv_sys_rules u_sys (
        .mode_i       (mode),
        .tvm_i        (ms_tvm_i),
        .tw_i         (ms_tw_i),
        .vtvm_i       (hs_vtvm_i),
        .vtw_i        (hs_vtw_i),
        .hu_i         (hs_hu_i),
        .ill_sfvma_o  (ill_sfvma),
        .ill_sfpart_o (ill_sfpart),
        .ill_hfg_o    (ill_hfg),
        .ill_hfv_o    (ill_hfv),
        .ill_hlsv_o   (ill_hlsv),
        .ill_wfi_o    (ill_wfi),
        .vi_sfvma_o   (vi_sfvma),
        .vi_sfpart_o  (vi_sfpart),
        .vi_hf_o      (vi_hf),
        .vi_hlsv_o    (vi_hlsv),
        .vi_wfi_o     (vi_wfi)
    );

    // index 0: zero, index 1: clean/flush
    assign cb_m_en = {menv_cbcfe_i, menv_cbze_i};
    assign cb_h_en = {henv_cbcfe_i, henv_cbze_i};
    assign cb_s_en = {senv_cbcfe_i, senv_cbze_i};

    for (genvar g = 0; g < N_CBEN; g++) begin : g_cben
        cbo_enable_rule u_rule (
            .mode_i (mode),
            .m_en_i (cb_m_en[g]),
            .h_en_i (cb_h_en[g]),
            .s_en_i (cb_s_en[g]),
            .ill_o  (cb_ill[g]),
            .vi_o   (cb_vi[g])
        );
    end

    cbo_inval_rule u_inval (
        .mode_i  (mode),
        .m_ctl_i (menv_cbie_i),
        .h_ctl_i (henv_cbie_i),
        .s_ctl_i (senv_cbie_i),
        .ill_o   (ill_cbi),
        .vi_o    (vi_cbi),
        .flush_o (inval_flush_o)
    );

    always_comb begin
        ill_d            = '0;
        ill_d[IL_SFVMA]  = ill_sfvma;
        ill_d[IL_SFPART] = ill_sfpart;
        ill_d[IL_HFG]    = ill_hfg;
        ill_d[IL_HFV]    = ill_hfv;
        ill_d[IL_HLSV]   = ill_hlsv;
        ill_d[IL_WFI]    = ill_wfi;
        ill_d[IL_CBZ]    = cb_ill[0];
        ill_d[IL_CBCF]   = cb_ill[1];
        ill_d[IL_CBI]    = ill_cbi;
        ill_d[IL_FP]     = (ms_fs_i == XS_OFF);
        ill_d[IL_VEC]    = (ms_vs_i == XS_OFF);
        ill_d[IL_FRM]    = (frm_i > FRM_LIM);

        vi_raw_d            = '0;
        vi_raw_d[VI_SFVMA]  = vi_sfvma;
        vi_raw_d[VI_SFPART] = vi_sfpart;
        vi_raw_d[VI_HF]     = vi_hf;
        vi_raw_d[VI_HLSV]   = vi_hlsv;
        vi_raw_d[VI_WFI]    = vi_wfi;
        vi_raw_d[VI_CBZ]    = cb_vi[0];
        vi_raw_d[VI_CBCF]   = cb_vi[1];
        vi_raw_d[VI_CBI]    = vi_cbi;

        // an illegal outcome pre-empts the virtual one of the same class
        vi_d            = vi_raw_d;
        vi_d[VI_SFVMA]  = vi_raw_d[VI_SFVMA]  & ~ill_d[IL_SFVMA];
        vi_d[VI_SFPART] = vi_raw_d[VI_SFPART] & ~ill_d[IL_SFPART];
        vi_d[VI_HF]     = vi_raw_d[VI_HF]     & ~(ill_d[IL_HFG] | ill_d[IL_HFV]);
        vi_d[VI_HLSV]   = vi_raw_d[VI_HLSV]   & ~ill_d[IL_HLSV];
        vi_d[VI_WFI]    = vi_raw_d[VI_WFI]    & ~ill_d[IL_WFI];
        vi_d[VI_CBZ]    = vi_raw_d[VI_CBZ]    & ~ill_d[IL_CBZ];
        vi_d[VI_CBCF]   = vi_raw_d[VI_CBCF]   & ~ill_d[IL_CBCF];
        vi_d[VI_CBI]    = vi_raw_d[VI_CBI]    & ~ill_d[IL_CBI];
    end

    assign ill_o = ill_d;
    assign vi_o  = vi_d;

endmodule

// File: rtl/priv_legal_chk.sv
module priv_legal_chk
    import priv_legal_pkg::*;
(
    input logic [LVL_W-1:0]  priv_lvl_i,
    input logic              priv_virt_i,
    input logic              ms_tw_i,
    input logic [XS_W-1:0]   ms_fs_i,
    input logic [XS_W-1:0]   ms_vs_i,
    input logic              menv_cbze_i,
    input logic [CBIE_W-1:0] menv_cbie_i,
    input logic [N_ILL-1:0]  ill_o,
    input logic [N_VIRT-1:0] vi_o,
    input logic              inval_flush_o
);

    logic in_m, in_hu, in_vu;

    always_comb begin
        in_m  = priv_lvl_i[1];
        in_hu = !priv_lvl_i[1] && !priv_lvl_i[0] && !priv_virt_i;
        in_vu = !priv_lvl_i[1] && !priv_lvl_i[0] &&  priv_virt_i;

        if (in_m) AST_M_QUIET: assert (ill_o[IL_CBI:0] == '0 && vi_o == '0 && !inval_flush_o); // R1
        if (in_hu) AST_HU_FENCE: assert (ill_o[IL_HFV:IL_SFVMA] == 4'hF); // R2
        if (in_vu) AST_VU_SFPART: assert (vi_o[VI_SFPART]); // R3
        if (priv_virt_i && !in_m) AST_GUEST_HLSV: assert (vi_o[VI_HLSV]); // R4
        if (!in_m && ms_tw_i) AST_TW_WFI: assert (ill_o[IL_WFI] && !vi_o[VI_WFI]); // R5
        if (ms_fs_i == XS_OFF) AST_FS_OFF: assert (ill_o[IL_FP]); // R6
        if (ms_vs_i == XS_OFF) AST_VS_OFF: assert (ill_o[IL_VEC]); // R6
        if (!in_m && !menv_cbze_i) AST_CBZ_MOFF: assert (ill_o[IL_CBZ] && !vi_o[VI_CBZ]); // R7
        if (!in_m && (menv_cbie_i == CBIE_OFF || menv_cbie_i == CBIE_RSVD))
            AST_CBI_MOFF: assert (ill_o[IL_CBI]); // R8
        if (!in_m && menv_cbie_i == CBIE_FLUSH) AST_CBI_FLUSH: assert (inval_flush_o); // R9
        if (!priv_virt_i) AST_NATIVE_NO_VI: assert (vi_o == '0); // R10
        AST_EXCLUSIVE: assert ((vi_o[VI_SFVMA] & ill_o[IL_SFVMA]) == 1'b0 &&
                               (vi_o[VI_WFI]   & ill_o[IL_WFI])   == 1'b0 &&
                               (vi_o[VI_CBZ]   & ill_o[IL_CBZ])   == 1'b0 &&
                               (vi_o[VI_CBCF]  & ill_o[IL_CBCF])  == 1'b0 &&
                               (vi_o[VI_CBI]   & ill_o[IL_CBI])   == 1'b0); // R10
    end

endmodule

bind priv_legal_check priv_legal_chk u_chk (
    .priv_lvl_i    (priv_lvl_i),
    .priv_virt_i   (priv_virt_i),
    .ms_tw_i       (ms_tw_i),
    .ms_fs_i       (ms_fs_i),
    .ms_vs_i       (ms_vs_i),
    .menv_cbze_i   (menv_cbze_i),
    .menv_cbie_i   (menv_cbie_i),
    .ill_o         (ill_o),
    .vi_o          (vi_o),
    .inval_flush_o (inval_flush_o)
);

// File: tb/test_priv_legal_check.sv
module test_priv_legal_check;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic [1:0] lvl;
        logic       virt;
        logic       tvm, tw, vtvm, vtw, hu;
        logic [1:0] fs, vs;
        logic [2:0] frm;
        logic       mz, mc;
        logic [1:0] mi;
        logic       hz, hc;
        logic [1:0] hi;
        logic       sz, sc;
        logic [1:0] si;
    } stim_t;

    typedef struct packed {
        stim_t       s;
        logic [11:0] ill;
        logic [7:0]  vi;
        logic        fl;
    } vec_t;

    localparam int N_VEC = 8;
    localparam vec_t TABLE [N_VEC] = '{
        // R1/R6: M, FS and VS off
        '{'{2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,3'd0, 1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0}, 12'h600, 8'h00, 1'b0},
        // R2/R5/R6/R9: HS with TVM, TW, frm 5, machine flush
        '{'{2'd1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd1,2'd1,3'd5, 1'b1,1'b1,2'd1, 1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0}, 12'h825, 8'h00, 1'b1},
        // R2/R4/R7/R8: HU, supervisor reserved invalidate control
        '{'{2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,3'd4, 1'b1,1'b0,2'd3, 1'b0,1'b0,2'd0, 1'b0,1'b1,2'd2}, 12'h1FF, 8'h00, 1'b0},
        // R3/R5/R7/R9: VS with VTVM and VTW, hypervisor flush
        '{'{2'd1,1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0, 2'd2,2'd0,3'd7, 1'b1,1'b1,2'd3, 1'b0,1'b1,2'd1, 1'b0,1'b0,2'd0}, 12'hC00, 8'h3D, 1'b1},
        // R3/R7/R8: VU
        '{'{2'd0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd1,3'd0, 1'b1,1'b1,2'd3, 1'b1,1'b0,2'd3, 1'b1,1'b1,2'd0}, 12'h000, 8'hDF, 1'b0},
        // R5/R7/R8/R9: VU with TW, machine zero and invalidate off
        '{'{2'd0,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b1, 2'd1,2'd1,3'd0, 1'b0,1'b1,2'd0, 1'b0,1'b0,2'd0, 1'b0,1'b0,2'd1}, 12'h160, 8'h4F, 1'b1},
        // R1: reserved level 2 counts as M
        '{'{2'd2,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd1,2'd1,3'd0, 1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0}, 12'h000, 8'h00, 1'b0},
        // R4/R10: HU with hypervisor load/store allowed
        '{'{2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,2'd1,3'd0, 1'b1,1'b1,2'd1, 1'b0,1'b0,2'd0, 1'b1,1'b1,2'd3}, 12'h02F, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    stim_t st;
    logic [11:0] ill;
    logic [7:0]  vi;
    logic        fl;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_legal_check i_priv_legal_check (
        .priv_lvl_i    (st.lvl),
        .priv_virt_i   (st.virt),
        .ms_tvm_i      (st.tvm),
        .ms_tw_i       (st.tw),
        .ms_fs_i       (st.fs),
        .ms_vs_i       (st.vs),
        .hs_vtvm_i     (st.vtvm),
        .hs_vtw_i      (st.vtw),
        .hs_hu_i       (st.hu),
        .frm_i         (st.frm),
        .menv_cbze_i   (st.mz),
        .menv_cbcfe_i  (st.mc),
        .menv_cbie_i   (st.mi),
        .henv_cbze_i   (st.hz),
        .henv_cbcfe_i  (st.hc),
        .henv_cbie_i   (st.hi),
        .senv_cbze_i   (st.sz),
        .senv_cbcfe_i  (st.sc),
        .senv_cbie_i   (st.si),
        .ill_o         (ill),
        .vi_o          (vi),
        .inval_flush_o (fl)
    );

    function automatic string ill_req(input int b);
        case (b)
            0, 1, 2, 3: return "R2";
            4:          return "R4";
            5:          return "R5";
            6, 7:       return "R7";
            8:          return "R8";
            default:    return "R6";
        endcase
    endfunction

    function automatic string vi_req(input int b);
        case (b)
            0, 1, 2: return "R3";
            3:       return "R4";
            4:       return "R5";
            5, 6:    return "R7";
            default: return "R8";
        endcase
    endfunction

    // reference model, written from the requirements
    function automatic logic [20:0] model(input stim_t s);
        logic m, hs, hu, vs, vu, low;
        logic [11:0] il;
        logic [7:0]  v;
        logic f, moff, hoff, soff;
        m  = (s.lvl >= 2'd2);
        hs = !m && s.lvl == 2'd1 && !s.virt;
        hu = !m && s.lvl == 2'd0 && !s.virt;
        vs = !m && s.lvl == 2'd1 &&  s.virt;
        vu = !m && s.lvl == 2'd0 &&  s.virt;
        low = !m;
        moff = (s.mi == 2'b00 || s.mi == 2'b10);
        hoff = (s.hi == 2'b00 || s.hi == 2'b10);
        soff = (s.si == 2'b00 || s.si == 2'b10);
        il = '0; v = '0;
        il[0]  = hu || (hs && s.tvm);
        il[1]  = hu;
        il[2]  = il[0];
        il[3]  = hu;
        il[4]  = hu && !s.hu;
        il[5]  = hu || (low && s.tw);
        il[6]  = (low && !s.mz) || (hu && !s.sz);
        il[7]  = (low && !s.mc) || (hu && !s.sc);
        il[8]  = (low && moff) || (hu && soff);
        il[9]  = (s.fs == 2'b00);
        il[10] = (s.vs == 2'b00);
        il[11] = (s.frm > 3'd4);
        v[0] = vu || (vs && s.vtvm);
        v[1] = vu;
        v[2] = vs || vu;
        v[3] = vs || vu;
        v[4] = !s.tw && (vu || (vs && s.vtw));
        v[5] = s.mz && ((vs && !s.hz) || (vu && (!s.hz || !s.sz)));
        v[6] = s.mc && ((vs && !s.hc) || (vu && (!s.hc || !s.sc)));
        v[7] = !moff && ((vs && hoff) || (vu && (hoff || soff)));
        // R10: illegal wins
        if (il[0]) v[0] = 1'b0;
        if (il[1]) v[1] = 1'b0;
        if (il[2] || il[3]) v[2] = 1'b0;
        if (il[4]) v[3] = 1'b0;
        if (il[5]) v[4] = 1'b0;
        if (il[6]) v[5] = 1'b0;
        if (il[7]) v[6] = 1'b0;
        if (il[8]) v[7] = 1'b0;
        f = (hs && s.mi == 2'b01) ||
            (hu && (s.mi == 2'b01 || s.si == 2'b01)) ||
            (vs && (s.mi == 2'b01 || s.hi == 2'b01)) ||
            (vu && (s.mi == 2'b01 || s.hi == 2'b01 || s.si == 2'b01));
        return {il, v, f};
    endfunction

    task automatic apply(input stim_t s);
        @(negedge clk);
        st = s;
        @(posedge clk);
        #1;
    endtask

    task automatic compare(input logic [11:0] e_ill, input logic [7:0] e_vi,
                           input logic e_fl, input string tag);
        bit bad = 1'b0;
        checks++;
        for (int b = 0; b < 12 && !bad; b++)
            if (ill[b] !== e_ill[b]) begin
                $display("FAIL %s %s ill_o[%0d] actual %0b expected %0b", ill_req(b), tag, b, ill[b], e_ill[b]);
                bad = 1'b1;
            end
        for (int b = 0; b < 8 && !bad; b++)
            if (vi[b] !== e_vi[b]) begin
                $display("FAIL %s %s vi_o[%0d] actual %0b expected %0b", vi_req(b), tag, b, vi[b], e_vi[b]);
                bad = 1'b1;
            end
        if (!bad && fl !== e_fl) begin
            $display("FAIL R9 %s inval_flush_o actual %0b expected %0b", tag, fl, e_fl);
            bad = 1'b1;
        end
        if (bad) errors++;
    endtask

    task automatic check_model(input stim_t s, input string tag);
        logic [20:0] e;
        e = model(s);
        compare(e[20:9], e[8:1], e[0], tag);
    endtask

    initial begin
        stim_t s;
        st = '0;
        st.lvl = 2'd3;
        st.fs = 2'd3;
        st.vs = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        // R1: quiet M state held during reset
        compare(12'h000, 8'h00, 1'b0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            apply(TABLE[i].s);
            compare(TABLE[i].ill, TABLE[i].vi, TABLE[i].fl, $sformatf("R1 R10 table %0d", i));
        end

        // sweep A: trap bits, FS/VS, rounding mode (R2 R3 R4 R5 R6 R10)
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 32; c++)
                for (int x = 0; x < 16; x++)
                    for (int r = 0; r < 8; r++) begin
                        s = '0;
                        {s.lvl, s.virt} = 3'(p);
                        {s.tvm, s.tw, s.vtvm, s.vtw, s.hu} = 5'(c);
                        {s.fs, s.vs} = 4'(x);
                        s.frm = 3'(r);
                        {s.mz, s.mc, s.hz, s.hc, s.sz, s.sc} = 6'h3F;
                        {s.mi, s.hi, s.si} = 6'h3F;
                        apply(s);
                        check_model(s, "sweepA");
                    end

        // sweep B: cache-block enables and controls (R7 R8 R9 R1)
        for (int p = 0; p < 8; p++)
            for (int e = 0; e < 64; e++)
                for (int k = 0; k < 64; k++) begin
                    s = '0;
                    {s.lvl, s.virt} = 3'(p);
                    {s.fs, s.vs} = 4'hF;
                    {s.mz, s.mc, s.hz, s.hc, s.sz, s.sc} = 6'(e);
                    {s.mi, s.hi, s.si} = 6'(k);
                    apply(s);
                    check_model(s, "sweepB");
                end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule